// File: doc/BRIEF.md
# Line-Rate Potentiometer Timer with Shared Bidirectional Pins

This block measures four resistive game-controller inputs by timing how long each one takes to charge past a threshold. Four pins are grouped into a left pair and a right pair. Each pair is read as one 16-bit word: the vertical counter sits in the high byte and the horizontal counter in the low byte. A write to the control word with its start bit set does three things. It clears every counter, raises a discharge output that empties the external timing capacitors, and then lets the counters step once per horizontal line tick. Each counter stops when its own pin, after two synchronising flops, reads high.

The same four pins also form a small general-purpose bidirectional port. The upper byte of the control word gives each pin an output-enable bit and a data bit. A pin that is being driven no longer stops its counter. A separate read path returns the synchronised level of each pin. Counting speed follows the line tick rate, so a faster line rate gives proportionally larger readings for the same resistance. A counter that never sees its pin cross stays at full scale.

Top module: `potport_top`

## Requirements
- R1: After reset both data words read 0, `dump` is low, and `pin_oe` and `pin_out` are all zero.
- R2: Pin index 3 is right vertical, 2 is right horizontal, 1 is left vertical and 0 is left horizontal. `left_word` is {counter 1, counter 0} and `right_word` is {counter 3, counter 2}, with the vertical counter in bits 15:8.
- R3: A control write with bit 0 set clears all four counters and raises `dump` on the next cycle. This applies from any phase, including while counting.
- R4: `dump` stays high for exactly 4 line ticks and falls on the cycle after the fourth. Ticks that arrive during the discharge do not advance any counter.
- R5: In the counting phase, each line tick adds 1 to every counter that is still running. No counter changes in a cycle without a tick.
- R6: A counter whose synchronised pin is high at a counting tick stops. It stays frozen until the next start, even if the pin later falls.
- R7: A counter saturates at 0xFF and does not wrap.
- R8: Control bits 15/14 are the output enable and data of pin 3, bits 13/12 those of pin 2, bits 11/10 those of pin 1, and bits 9/8 those of pin 0 (enable in the higher bit). `pin_oe` and `pin_out` take the new values on the cycle after the write. Bits 7:1 have no effect.
- R9: A pin whose output enable is set does not stop its counter.
- R10: `pin_levels` equals `pin_in` delayed by two clock cycles.
- R11: A control write with bit 0 clear changes only the port bits. It neither restarts nor clears the counters, and it does not raise `dump`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: port enables/data in 15:8, start in bit 0 |
| pin_in | input | 4 | Threshold-crossed level of each pin, sampled asynchronously |
| pin_oe | output | 4 | Output enable for each pin |
| pin_out | output | 4 | Data driven on each enabled pin |
| dump | output | 1 | Capacitor discharge, high during the dump phase |
| left_word | output | 16 | Left pair counters {vertical, horizontal} |
| right_word | output | 16 | Right pair counters {vertical, horizontal} |
| pin_levels | output | 4 | Synchronised pin levels |

## Verification
A wrong phase or a wrong discharge count shows at `dump` and in the data words on the first tick after the fault: counting starts too early, too late, or never. A lost stop latch shows as a counter that starts moving again when its pin drops, on the very next tick. A swapped pin-to-field mapping shows as a value landing in the wrong byte. Random stop points and random port settings against a per-tick reference model catch each of these within one line tick of its cause.

// File: rtl/potport_pkg.sv
`timescale 1ns/1ps
package potport_pkg;

    localparam int NUM_PINS   = 4;
    localparam int CTRL_W     = 16;
    localparam int START_BIT  = 0;
    localparam int PORT_LSB   = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DUMP  = 2'd1,
        PH_COUNT = 2'd2
    } phase_e;

    typedef struct packed {
        logic oe;
        logic dat;
    } pin_ctl_t;

    typedef pin_ctl_t [NUM_PINS-1:0] port_ctl_t;

    // Pin i owns the bit pair {PORT_LSB+2i+1 (enable), PORT_LSB+2i (data)}.
    function automatic port_ctl_t decode_port(input logic [CTRL_W-1:0] w);
        port_ctl_t r;
        for (int i = 0; i < NUM_PINS; i++) begin
            r[i].oe  = w[PORT_LSB + 2*i + 1];
            r[i].dat = w[PORT_LSB + 2*i];
        end
        return r;
    endfunction

endpackage

// File: rtl/potport_sync.sv
`timescale 1ns/1ps
module potport_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/potport_seq.sv
`timescale 1ns/1ps
module potport_seq
    import potport_pkg::*;
#(
    parameter int DUMP_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic line_tick,
    output logic dump_o,
    output logic count_tick_o
);
    localparam int DW = $clog2(DUMP_TICKS + 1);

    phase_e        phase_q;
    logic [DW-1:0] dump_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            dump_cnt_q <= '0;
        end else if (start) begin
            phase_q    <= PH_DUMP;
            dump_cnt_q <= '0;
        end else if (phase_q == PH_DUMP && line_tick) begin
            if (dump_cnt_q == DW'(DUMP_TICKS - 1)) begin
                phase_q <= PH_COUNT;
            end else begin
                dump_cnt_q <= dump_cnt_q + 1'b1;
            end
        end
    end

    assign dump_o       = (phase_q == PH_DUMP);
    assign count_tick_o = (phase_q == PH_COUNT) && line_tick;

    // R4: discharge and counting never overlap
    a_r4_dump_exclusive: assert property (@(posedge clk) disable iff (rst)
        dump_o |-> !count_tick_o);

    // R4: discharge cannot end without a tick
    a_r4_dump_needs_tick: assert property (@(posedge clk) disable iff (rst)
        dump_o && !line_tick && !start |=> dump_o);

    // R3: once counting, only a start leaves the phase
    a_r3_count_sticky: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_COUNT && !start |=> phase_q == PH_COUNT);
endmodule

// File: rtl/potport_cnt.sv
`timescale 1ns/1ps
module potport_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             stop,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             stopped_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q     <= '0;
            stopped_q <= 1'b0;
        end else if (tick && !stopped_q) begin
            if (stop) begin
                stopped_q <= 1'b1;
            end else if (cnt_q != FULL) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign value = cnt_q;

    // R5: at most one step per cycle, never backwards outside a clear
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

    // R5: no tick, no change
    a_r5_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !clr && !tick |=> $stable(cnt_q));

    // R6: a stopped counter is frozen
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        stopped_q && !clr |=> $stable(cnt_q) && stopped_q);

    // R7: full scale holds
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        cnt_q == FULL && !clr |=> cnt_q == FULL);
endmodule

// File: rtl/potport_top.sv
`timescale 1ns/1ps
module potport_top
    import potport_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DUMP_TICKS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_tick,
    input  logic                  ctrl_we,
    input  logic [CTRL_W-1:0]     ctrl_wdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic                  dump,
    output logic [2*CNT_W-1:0]    left_word,
    output logic [2*CNT_W-1:0]    right_word,
    output logic [NUM_PINS-1:0]   pin_levels
);
    localparam int WORD_W = 2 * CNT_W;

    port_ctl_t             port_q;
    logic                  start;
    logic                  count_tick;
    logic [NUM_PINS-1:0]   pin_sync;
    logic [NUM_PINS-1:0]   stop_req;
    logic [CNT_W-1:0]      cnt_val [NUM_PINS];

    assign start = ctrl_we && ctrl_wdata[START_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
        end else if (ctrl_we) begin
            port_q <= decode_port(ctrl_wdata);
        end
    end

    potport_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    potport_seq #(.DUMP_TICKS(DUMP_TICKS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .line_tick    (line_tick),
        .dump_o       (dump),
        .count_tick_o (count_tick)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_oe[i]   = port_q[i].oe;
        assign pin_out[i]  = port_q[i].dat;
        assign stop_req[i] = pin_sync[i] && !port_q[i].oe;

        potport_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (start),
            .tick  (count_tick),
            .stop  (stop_req[i]),
            .value (cnt_val[i])
        );
    end

    assign left_word  = WORD_W'({cnt_val[1], cnt_val[0]});
    assign right_word = WORD_W'({cnt_val[3], cnt_val[2]});
    assign pin_levels = pin_sync;

    // R3: start clears both words and begins discharge
    a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> dump && left_word == '0 && right_word == '0);

    // R8: reserved low bits never start a measurement
    a_r8_reserved_no_start: assert property (@(posedge clk) disable iff (rst)
        ctrl_we && !ctrl_wdata[START_BIT] && (ctrl_wdata[7:1] != '0) && !dump |=> !dump);

    // R11: a plain write leaves the counters where they were
    a_r11_plain_write_keeps: assert property (@(posedge clk) disable iff (rst)
        ctrl_we && !ctrl_wdata[START_BIT] && !line_tick |=> $stable(left_word) && $stable(right_word));

    // R8: port bits follow the write on the next cycle
    a_r8_port_update: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> pin_oe == {$past(ctrl_wdata[15]), $past(ctrl_wdata[13]),
                               $past(ctrl_wdata[11]), $past(ctrl_wdata[9])});
endmodule

// File: tb/potport_top_tb_top.sv
`timescale 1ns/1ps
module potport_top_tb_top;

    localparam int DUMP_N   = 4;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_tick = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_oe;
    logic [3:0]  pin_out;
    logic        dump;
    logic [15:0] left_word;
    logic [15:0] right_word;
    logic [3:0]  pin_levels;

    always #2.5 clk = ~clk;

    potport_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .line_tick  (line_tick),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .dump       (dump),
        .left_word  (left_word),
        .right_word (right_word),
        .pin_levels (pin_levels)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    int exp_cnt [4];
    bit exp_stop[4];
    bit exp_oe  [4];
    bit exp_dat [4];
    int phase = 0;      // 0 idle, 1 dump, 2 count
    int dump_left = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int hi, input int lo);
        return {hi[7:0], lo[7:0]};
    endfunction

    function automatic logic [3:0] oe_vec();
        return {exp_oe[3], exp_oe[2], exp_oe[1], exp_oe[0]};
    endfunction

    function automatic logic [3:0] dat_vec();
        return {exp_dat[3], exp_dat[2], exp_dat[1], exp_dat[0]};
    endfunction

    task automatic check_words(input string req);
        chk(req, left_word,  word_of(exp_cnt[1], exp_cnt[0]));
        chk(req, right_word, word_of(exp_cnt[3], exp_cnt[2]));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R8 / R3 / R11: control write and its visible effect one cycle later
    task automatic write_ctrl(input logic [15:0] d);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_we    = 1'b0;
        for (int i = 0; i < 4; i++) begin
            exp_oe[i]  = d[9 + 2*i];
            exp_dat[i] = d[8 + 2*i];
        end
        if (d[0]) begin
            for (int i = 0; i < 4; i++) begin
                exp_cnt[i]  = 0;
                exp_stop[i] = 1'b0;
            end
            phase     = 1;
            dump_left = DUMP_N;
            chk("R3 dump after start", dump, 1'b1);
            check_words("R3 cleared");
        end else begin
            chk("R11 dump unchanged", dump, phase == 1);
            check_words("R11 counters kept");
        end
        chk("R8 pin_oe", pin_oe, oe_vec());
        chk("R8 pin_out", pin_out, dat_vec());
    endtask

    task automatic tick();
        repeat (3) @(negedge clk);
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        if (phase == 2) begin
            for (int i = 0; i < 4; i++) begin
                if (!exp_stop[i]) begin
                    if (pin_in[i] && !exp_oe[i]) exp_stop[i] = 1'b1;
                    else if (exp_cnt[i] < 255) exp_cnt[i]++;
                end
            end
            check_words("R5 tick count");
        end else if (phase == 1) begin
            dump_left--;
            if (dump_left == 0) phase = 2;
            check_words("R4 no count in dump");
        end else begin
            check_words("R5 idle");
        end
        chk("R4 dump level", dump, phase == 1);
    endtask

    // start, then DUMP_N ticks and n count ticks; pin i rises before count tick k[i]
    task automatic run(input logic [15:0] start_word, input int k0, input int k1,
                       input int k2, input int k3, input int n,
                       input int mid_at, input logic [15:0] mid_word);
        int k[4];
        k[0] = k0; k[1] = k1; k[2] = k2; k[3] = k3;
        pin_in = '0;
        write_ctrl(start_word);
        for (int j = 0; j < DUMP_N; j++) begin
            for (int i = 0; i < 4; i++) pin_in[i] = (k[i] == 0);
            tick();
        end
        for (int j = 0; j < n; j++) begin
            if (j == mid_at) write_ctrl(mid_word);
            for (int i = 0; i < 4; i++) pin_in[i] = (j >= k[i]);
            tick();
        end
    endtask

    initial begin
        #(WD_LIMIT * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4; i++) begin
            exp_cnt[i] = 0; exp_stop[i] = 0; exp_oe[i] = 0; exp_dat[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 left_word", left_word, 16'h0);
        chk("R1 right_word", right_word, 16'h0);
        chk("R1 dump", dump, 1'b0);
        chk("R1 pin_oe", pin_oe, 4'h0);
        chk("R1 pin_out", pin_out, 4'h0);

        // R10: two-cycle pin synchronisation
        pin_in = 4'b1010;
        @(negedge clk);
        chk("R10 not yet", pin_levels, 4'b0000);
        @(negedge clk);
        chk("R10 after two", pin_levels, 4'b1010);
        pin_in = 4'b0000;
        repeat (3) @(negedge clk);

        // R8: port write, reserved bits set, no start
        write_ctrl(16'hA5FE);
        chk("R8 mapping oe", pin_oe, 4'b1100);
        chk("R8 mapping data", pin_out, 4'b0011);
        tick();
        chk("R8 reserved bits no dump", dump, 1'b0);

        // R6 / R7 / R2: directed run, pin0 at once, pin1 after 1, pin2 after 10, pin3 never
        run(16'h0001, 0, 1, 10, 1000, 300, -1, 16'h0);
        chk("R7 saturated", right_word[15:8], 8'hFF);
        chk("R2 left horizontal", left_word[7:0], 8'h00);
        chk("R2 left vertical", left_word[15:8], 8'h01);
        chk("R2 right horizontal", right_word[7:0], 8'h0A);
        pin_in = 4'b0000;
        for (int j = 0; j < 5; j++) tick();
        chk("R6 frozen after drop", left_word, 16'h0100);
        repeat (10) @(negedge clk);
        check_words("R5 no tick no change");

        // R9 / R3: driven pin 2 never stops; restart while counting
        run(16'h2001, 3, 5, 0, 7, 20, -1, 16'h0);
        chk("R9 driven pin counts", right_word[7:0], 8'd20);
        write_ctrl(16'h0001);
        chk("R3 restart mid count", {left_word, right_word}, 32'h0);

        // random runs with a mid-run plain write
        for (int r = 0; r < 4; r++) begin
            logic [15:0] sw;
            logic [15:0] mw;
            sw = {8'($urandom), 8'h01};
            mw = {8'($urandom), 7'($urandom), 1'b0};
            run(sw, $urandom_range(0, 280), $urandom_range(0, 280),
                $urandom_range(0, 280), $urandom_range(0, 280),
                270, $urandom_range(20, 200), mw);
        end

        finish_run();
    end

endmodule